// File: doc/BRIEF.md
# Systolic Incremental Pixel Shader Array

This block turns a stream of scanline commands into one row of pixel colours. It is a chain of N identical pixel elements, one per pixel of the row. A command enters the leftmost element as a short serial packet on a 32-bit bus, one word per clock. Each word moves one element to the right on every clock. As the packet passes, each element decides whether the command covers its own pixel. If it does, the element updates its accumulated colour and the intensity terms, and then hands the adjusted values on to its right neighbour. Because of this, shading along a span needs only additions, which are spread across the elements.

A position check costs one decrement per element. The packet's first word holds a position X (low half) and a period DX (high half). Each element passes X minus one to its right. An element that receives zero is hit, and it forwards DX minus one in place of X-1. A span command therefore starts at X and ends at X+DX. Store and disable commands hit every pixel at X, X+DX, X+2DX and so on.

When a REFRESH word passes an element, that element captures its colour and clears all of its state. Once the word has passed the last element, the captured colours leave the block serially, leftmost pixel first, each with a valid strobe. Commands for the next row can follow right behind the REFRESH.

Top module: `pixel_shade_array`

## Requirements
- R1: After reset, and after any later reset, every pixel colour reads as zero. pix_valid stays low until a REFRESH is read out.
- R2: cmd_op encodes NOP=0, EVAL1=1, EVAL2=2, EVAL3=3, EVAL4=4, SETI=5, SETDI=6, SETDDI=7, DIS=8, REFRESH=9. cmd_slot numbers the words of a packet from 0 upward. Slot 0 carries X in bits [11:0] and DX in bits [27:16]. EVAL1 then sends DDI, DI and I in slots 1 to 3. EVAL2 sends DI and I in slots 1 and 2. EVAL3 sends I in slot 1. A SET command sends its value in slot 1.
- R3: EVAL1, EVAL2 and EVAL3 act on pixels X up to X+DX-1. The command stops at pixel X+DX. Pixels to its right, and pixels past the end of the row, are untouched.
- R4: EVAL1 works through its span from left to right. At each pixel it does colour += I, then I += DI, then DI += DDI, all using the values that arrived at that pixel.
- R5: EVAL2 does colour += I and then I += DI at each pixel, with DI held constant.
- R6: EVAL3 adds the same I to every pixel of its span. All intensity sums wrap modulo 2^32.
- R7: EVAL4 is one word, with X in bits [11:0] and a 16-bit value in bits [31:16]. It overwrites the colour of pixel X only with that value, zero-extended.
- R8: SETI, SETDI and SETDDI store their value at pixels X, X+DX, X+2DX and so on, and protect it there. Where a pixel is protected, the next EVAL uses the stored value in place of the incoming one, and carries that value on to the right.
- R9: On the last word of an EVAL, every element that word reaches clears its protect and disable flags. That means the elements up to and including the span's end pixel. A SET therefore shapes only one EVAL.
- R10: DIS marks pixels X, X+DX and so on. At a marked pixel, the next EVAL leaves the colour unchanged but still carries its increments on to the right.
- R11: REFRESH clears every colour. After the REFRESH word is presented, pix_valid rises N+1 clocks later and stays high for exactly N clocks, carrying pixels 0 to N-1 in order.
- R12: NOP words change no pixel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 4 | Opcode of the current command word |
| cmd_slot | input | 2 | Index of the word within its packet |
| cmd_data | input | 32 | Command word data |
| pix_out | output | 32 | Serial pixel colour |
| pix_valid | output | 1 | pix_out holds a pixel |

## Verification
The assertions check on every cycle that the systolic chain itself is sound. A NOP can never turn into a live command further down the chain. A command word keeps its slot index as it moves from element to element. An element's colour is zero on the clock after a REFRESH passes it. Readout starts two clocks after the REFRESH reaches the last element and never runs longer than N pixels. Only the bench's scenarios can show the arithmetic. The tests cover span start and end positions, the three increment orders, protection lasting for exactly one EVAL, flags that survive to the right of a span's end, disabled pixels, and wrap-around of the sums. For each of these, the bench compares every pixel of the row with an independent model.

// File: rtl/pixel_shade_pe.sv
module pixel_shade_pe #(
  parameter int XW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  i_op,
  input  logic [1:0]  i_slot,
  input  logic [31:0] i_data,
  input  logic        i_ev,
  output logic [3:0]  o_op,
  output logic [1:0]  o_slot,
  output logic [31:0] o_data,
  output logic        o_ev,
  output logic [31:0] colour,
  output logic        ref_hit
);
  localparam logic [3:0] OP_NOP = 4'd0, OP_E1 = 4'd1, OP_E2 = 4'd2, OP_E3 = 4'd3,
                         OP_E4 = 4'd4, OP_SI = 4'd5, OP_SDI = 4'd6, OP_SDDI = 4'd7,
                         OP_DIS = 4'd8, OP_REF = 4'd9;
  localparam logic [1:0] K_NONE = 2'd0, K_I = 2'd1, K_DI = 2'd2, K_DDI = 2'd3;

  logic [31:0] r_i, r_di, r_ddi;
  logic p_i, p_di, p_ddi, dis, act_q, kill_q;

  logic [XW-1:0] x, dx, x_nx;
  logic hit, head, is_e13, is_ev, is_set, act_n, kill_n, ev_n, cur_act, cur_kill;
  logic [1:0] last, kind;
  logic [31:0] i_e, di_e, ddi_e, d_n;

  assign x      = i_data[XW-1:0];
  assign dx     = i_data[16+XW-1:16];
  assign hit    = (x == '0);
  assign x_nx   = hit ? dx - 1'b1 : x - 1'b1;
  assign head   = (i_slot == 2'd0);
  assign is_e13 = (i_op >= OP_E1) && (i_op <= OP_E3);
  assign is_ev  = (i_op >= OP_E1) && (i_op <= OP_E4);
  assign is_set = (i_op >= OP_SI) && (i_op <= OP_SDDI);
  assign ref_hit = (i_op == OP_REF);

  assign i_e   = p_i   ? r_i   : i_data;
  assign di_e  = p_di  ? r_di  : i_data;
  assign ddi_e = p_ddi ? r_ddi : i_data;

  always_comb begin
    case (i_op)
      OP_E1:                 last = 2'd3;
      OP_E2:                 last = 2'd2;
      OP_E3, OP_SI, OP_SDI,
      OP_SDDI:               last = 2'd1;
      default:               last = 2'd0;
    endcase
    kind = K_NONE;
    case (i_op)
      OP_E1: kind = (i_slot == 2'd1) ? K_DDI : (i_slot == 2'd2) ? K_DI :
                    (i_slot == 2'd3) ? K_I : K_NONE;
      OP_E2: kind = (i_slot == 2'd1) ? K_DI : (i_slot == 2'd2) ? K_I : K_NONE;
      OP_E3: kind = (i_slot == 2'd1) ? K_I : K_NONE;
      default: kind = K_NONE;
    endcase
  end

  always_comb begin
    act_n = 1'b0; kill_n = 1'b0; ev_n = 1'b0;
    if (is_e13) begin
      act_n  = hit ? !i_ev : i_ev;
      kill_n = hit && i_ev;
      ev_n   = hit ? !i_ev : i_ev;
    end else if (i_op == OP_E4) begin
      act_n  = hit;
      kill_n = hit;
    end else if (is_set || i_op == OP_DIS) begin
      act_n  = hit;
    end
  end

  assign cur_act  = head ? act_n  : act_q;
  assign cur_kill = head ? kill_n : kill_q;

  always_comb begin
    d_n = i_data;
    if (head && (is_ev || is_set || i_op == OP_DIS))
      d_n[XW-1:0] = x_nx;
    else if (is_ev && cur_act) begin
      case (kind)
        K_DDI:   d_n = ddi_e;
        K_DI:    d_n = di_e + ((i_op == OP_E1) ? r_ddi : 32'd0);
        K_I:     d_n = i_e + ((i_op != OP_E3) ? r_di : 32'd0);
        default: d_n = i_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_op <= OP_NOP; o_slot <= '0; o_data <= '0; o_ev <= 1'b0;
    end else begin
      o_op   <= cur_kill ? OP_NOP : i_op;
      o_slot <= i_slot;
      o_data <= d_n;
      o_ev   <= head && ev_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ref_hit) begin
      colour <= '0; r_i <= '0; r_di <= '0; r_ddi <= '0;
      p_i <= 1'b0; p_di <= 1'b0; p_ddi <= 1'b0; dis <= 1'b0;
      act_q <= 1'b0; kill_q <= 1'b0;
    end else begin
      if (head) begin
        act_q  <= act_n;
        kill_q <= kill_n;
      end
      if (is_ev && cur_act) begin
        case (kind)
          K_DDI: r_ddi <= ddi_e;
          K_DI:  r_di  <= di_e;
          K_I: begin
            r_i <= i_e;
            if (!dis) colour <= colour + i_e;
          end
          default: ;
        endcase
        if (i_op == OP_E4 && !dis)
          colour <= p_i ? r_i : {16'd0, i_data[31:16]};
      end
      if (is_set && i_slot == 2'd1 && cur_act) begin
        case (i_op)
          OP_SI:   begin r_i   <= i_data; p_i   <= 1'b1; end
          OP_SDI:  begin r_di  <= i_data; p_di  <= 1'b1; end
          default: begin r_ddi <= i_data; p_ddi <= 1'b1; end
        endcase
      end
      if (i_op == OP_DIS && head && hit) dis <= 1'b1;
      if (is_ev && i_slot == last) begin
        p_i <= 1'b0; p_di <= 1'b0; p_ddi <= 1'b0; dis <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixel_shade_array.sv
module pixel_shade_array #(
  parameter int N  = 16,
  parameter int XW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cmd_op,
  input  logic [1:0]  cmd_slot,
  input  logic [31:0] cmd_data,
  output logic [31:0] pix_out,
  output logic        pix_valid
);
  localparam int CW = $clog2(N + 1);

  logic [N:0][3:0]    opc;
  logic [N:0][1:0]    slotc;
  logic [N:0][31:0]   datac;
  logic [N:0]         evc;
  logic [N-1:0][31:0] colc;
  logic [N-1:0][31:0] cap;
  logic [N-1:0]       refc;
  logic [CW-1:0]      cnt;

  assign opc[0]   = cmd_op;
  assign slotc[0] = cmd_slot;
  assign datac[0] = cmd_data;
  assign evc[0]   = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_pe
    pixel_shade_pe #(.XW(XW)) u_pe (
      .clk(clk), .rst_n(rst_n),
      .i_op(opc[k]), .i_slot(slotc[k]), .i_data(datac[k]), .i_ev(evc[k]),
      .o_op(opc[k+1]), .o_slot(slotc[k+1]), .o_data(datac[k+1]), .o_ev(evc[k+1]),
      .colour(colc[k]), .ref_hit(refc[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)          cap[k] <= '0;
      else if (refc[k])    cap[k] <= colc[k];
      else if (cnt != '0)  cap[k] <= (k == N - 1) ? 32'd0 : cap[(k + 1) % N];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; pix_out <= '0; pix_valid <= 1'b0;
    end else if (refc[N-1]) begin
      cnt <= CW'(N); pix_valid <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1; pix_out <= cap[0]; pix_valid <= 1'b1;
    end else begin
      pix_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pixel_shade_array_chk.sv
module pixel_shade_array_chk #(
  parameter int N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N:0][3:0]   opc,
  input logic [N:0][1:0]   slotc,
  input logic [N-1:0][31:0] colc,
  input logic              pix_valid
);
  localparam int RW = $clog2(N + 2);
  logic [RW-1:0] vrun;

  always_ff @(posedge clk) begin
    if (!rst_n)         vrun <= '0;
    else if (pix_valid) vrun <= vrun + 1'b1;
    else                vrun <= '0;
  end

  a_r11_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (vrun < RW'(N)));

  a_r11_readout_start: assert property (@(posedge clk) disable iff (!rst_n)
    (opc[N-1] == 4'd9) |=> ##1 pix_valid);

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r12_nop_stays_nop: assert property (@(posedge clk) disable iff (!rst_n)
      (opc[k] == 4'd0) |=> (opc[k+1] == 4'd0));

    a_r2_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (opc[k] != 4'd0) |=> (slotc[k+1] == $past(slotc[k])));

    a_r11_colour_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (opc[k] == 4'd9) |=> (colc[k] == 32'd0));
  end
endmodule

bind pixel_shade_array pixel_shade_array_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .opc(opc), .slotc(slotc), .colc(colc), .pix_valid(pix_valid)
);

// File: tb/pixel_shade_array_tb.sv
module pixel_shade_array_tb_top;
  localparam int N = 16;
  localparam int NV = 28;
  localparam int NOP = 0, E1 = 1, E2 = 2, E3 = 3, E4 = 4, SI = 5, SDI = 6, SDDI = 7, DIS = 8, REF = 9;

  localparam int T_OP[NV] = '{REF, E3, E2, E1, E3, E3, E3, E3, REF, E3, E4, SI, E3, E3,
                              REF, DIS, E2, E3, SDI, E2, SDDI, E1, SI, E3, E3, REF, NOP, REF};
  localparam int T_X[NV]  = '{0, 2, 0, 5, 3, 12, 12, 14, 0, 8, 9, 1, 0, 0,
                              0, 4, 2, 4, 10, 8, 2, 0, 13, 0, 12, 0, 0, 0};
  localparam int T_DX[NV] = '{0, 3, 4, 4, 2, 1, 1, 10, 0, 3, 0, 5, 16, 16,
                              0, 100, 5, 1, 100, 6, 100, 5, 100, 4, 3, 0, 0, 0};
  localparam logic [31:0] T_A[NV] = '{0, 5, 10, 100, 7, 32'hFFFF_FFFF, 1, 9, 0, 2, 32'h1234, 50, 1, 1,
                                      0, 0, 10, 3, 5, 0, 2, 0, 77, 1, 0, 0, 0, 0};
  localparam logic [31:0] T_B[NV] = '{0, 0, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                      0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [31:0] T_C[NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                      0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_slot = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] pix_out;
  logic pix_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] mcol[N], msi[N], msdi[N], msddi[N];
  bit mpi[N], mpdi[N], mpddi[N], mdis[N];

  pixel_shade_array #(.N(N), .XW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
    .pix_out(pix_out), .pix_valid(pix_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic word(input int op, input int slot, input logic [31:0] d);
    @(negedge clk);
    cmd_op = 4'(op); cmd_slot = 2'(slot); cmd_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_op = 4'd0; cmd_slot = 2'd0; cmd_data = '0;
  endtask

  function automatic void clear_flags(int upto);
    for (int p = 0; p < N && p <= upto; p++) begin
      mpi[p] = 0; mpdi[p] = 0; mpddi[p] = 0; mdis[p] = 0;
    end
  endfunction

  function automatic void model(int op, int x, int dx, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] ci, cdi, cddi, ie, die, ddie;
    ci = a; cdi = b; cddi = c;
    if (op >= E1 && op <= E3) begin
      for (int p = x; p < x + dx && p < N; p++) begin
        ddie = (op == E1 && mpddi[p]) ? msddi[p] : cddi;
        die  = (op != E3 && mpdi[p]) ? msdi[p] : cdi;
        ie   = mpi[p] ? msi[p] : ci;
        if (!mdis[p]) mcol[p] = mcol[p] + ie;
        ci   = ie + ((op != E3) ? die : 32'd0);
        cdi  = die + ((op == E1) ? ddie : 32'd0);
        cddi = ddie;
      end
      clear_flags(x + dx);
    end else if (op == E4) begin
      if (x < N && !mdis[x]) mcol[x] = mpi[x] ? msi[x] : {16'd0, a[15:0]};
      clear_flags(x);
    end else if (op >= SI && op <= DIS) begin
      for (int p = x; p < N; p += dx) begin
        if (op == SI)   begin msi[p] = a;   mpi[p] = 1; end
        if (op == SDI)  begin msdi[p] = a;  mpdi[p] = 1; end
        if (op == SDDI) begin msddi[p] = a; mpddi[p] = 1; end
        if (op == DIS)  mdis[p] = 1;
      end
    end else if (op == REF) begin
      for (int p = 0; p < N; p++) mcol[p] = '0;
      clear_flags(N);
    end
  endfunction

  task automatic send(int op, int x, int dx, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] w0;
    w0 = (op == E4) ? {a[15:0], 16'(x)} : {16'(dx), 16'(x)};
    word(op, 0, w0);
    case (op)
      E1: begin word(op, 1, c); word(op, 2, b); word(op, 3, a); end
      E2: begin word(op, 1, b); word(op, 2, a); end
      E3, SI, SDI, SDDI: word(op, 1, a);
      default: ;
    endcase
    model(op, x, dx, a, b, c);
  endtask

  task automatic readout(input string req);
    int k, got, lat;
    word(REF, 0, 32'd0);
    idle();
    k = 1; got = 0; lat = -1;
    while (k < 8 * N && got < N) begin
      if (pix_valid) begin
        if (lat < 0) lat = k;
        chk(pix_out == mcol[got], req, pix_out, mcol[got]);
        got++;
      end
      @(negedge clk);
      k++;
    end
    chk(lat == N + 1, "R11 latency", 32'(lat), 32'(N + 1));
    chk(got == N, "R11 count", 32'(got), 32'(N));
    @(negedge clk);
    chk(pix_valid == 1'b0, "R11 burst end", 32'(pix_valid), 32'd0);
    model(REF, 0, 0, 0, 0, 0);
  endtask

  function automatic string tag_of(int r);
    case (r)
      0:  return "R1 reset row";
      8:  return "R2 R3 R4 R5 R6 spans";
      14: return "R7 R8 R9 overwrite/protect";
      25: return "R10 R8 R9 disable/protect";
      default: return "R12 R11 nop/clear";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual %0d expected 0", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      mcol[p] = '0; msi[p] = '0; msdi[p] = '0; msddi[p] = '0;
    end
    clear_flags(N);
    repeat (4) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid in reset", 32'(pix_valid), 32'd0);
    rst_n = 1'b1;
    // table walk: each REFRESH row reads the whole row and compares it with the model
    for (int r = 0; r < NV; r++) begin
      if (T_OP[r] == REF) readout(tag_of(r));
      else send(T_OP[r], T_X[r], T_DX[r], T_A[r], T_B[r], T_C[r]);
      idle();
    end
    // R1: reset in mid-row wipes accumulated colour
    send(E3, 0, 16, 32'd5, 0, 0);
    repeat (N + 2) idle();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    model(REF, 0, 0, 0, 0, 0);
    readout("R1 after reset");
    // R3: span ending exactly at last pixel, pixel 0 untouched by later-start span
    send(E3, 15, 1, 32'd4, 0, 0);
    send(E3, 1, 2, 32'd6, 0, 0);
    idle();
    readout("R3 edge spans");
    // R6: wrap under EVAL2 increment
    send(E2, 0, 3, 32'hFFFF_FFFE, 32'd1, 0);
    idle();
    readout("R6 wrap increment");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule